// File: doc/BRIEF.md
# Compare-Match Timer Channel

This block is one 16-bit up-counting timer channel. A prescaler derived from the bus clock, or a synchronised external clock input, produces count ticks. The counter can be cleared when it matches one of up to four compare registers, or from a synchronous clear input. Two output pins take a programmed starting level and are cleared, set or toggled when the counter matches the first or second compare register. Either pin can instead act as a capture input that latches the counter into its compare register.

Software reaches the channel through a small register window. Eight-bit registers use the low data byte. The counter and compare registers are accessed as halfwords. The run bit for the channel comes from a shared start vector outside the block. Each event sets a status flag, and the interrupt line goes high when a flag is set and its enable bit is on. Software clears a flag by reading it as 1 and then writing 0 to that bit.

Top module: `cmt_channel`

## Requirements
- R1: After reset the counter reads 0, every compare register reads 0xFFFF, the control, mode, IO-control and interrupt-enable registers read 0, status reads 0x80, both pins are low and irq is low.
- R2: The counter advances only while run_vec bit CHAN_IDX (0 by default) is 1 and the mode register low nibble is 0. Other run_vec bits are ignored. A non-zero mode value holds the counter.
- R3: Control bits 2:0 set the tick source. Codes 0 to 5 give one tick every 1, 4, 16, 64, 256 or 1024 running cycles, with the first tick on the N-th running clock edge, and the divider restarts whenever the channel stops. Code 6 counts edges of ext_clk after a two-flop synchroniser, with control bits 4:3 choosing 0 rising, 1 falling, 2 both, 3 none. Code 7 never ticks.
- R4: Control bits 7:5 choose the clear source: 1 compare A, 2 B, 5 C, 6 D. On a tick where the counter equals the selected register, the counter becomes 0 instead of incrementing. Code 3 clears the counter on the next edge while the channel is running and sync_clr is 1; this takes priority over a tick. Codes 0, 4 and 7 never clear.
- R5: A tick at 0xFFFF with no clear wraps the counter to 0 and sets status bit 4 (overflow).
- R6: A tick where the counter equals compare register A, B, C or D sets status bit 0, 1, 2 or 3, unless that register is in capture mode.
- R7: A status flag clears when a status read that saw it as 1 is followed by a status write with that bit 0. Any status write ends the pending read. Writing 0 without a prior read, or writing 1, leaves the flag set. A new event in the same cycle wins over a clear.
- R8: IO-control bits 3:0 drive pin_a_out and bits 7:4 drive pin_b_out. Writing code 1, 2 or 3 drives the pin low at once, and 5, 6 or 7 drives it high. On a compare A (pin A) or compare B (pin B) match, codes 1/5 clear the pin, 2/6 set it and 3/7 toggle it. Code 0 and other codes keep the level.
- R9: IO code 8, 9 or 10 captures the counter into compare A (pin A) or B (pin B) on a rising, falling or either edge of the synchronised pin input, and sets that compare flag. The captured value is the counter at the edge that is SYNC_STAGES cycles after the input changes.
- R10: irq is the OR over status bits 5:0 of (flag AND interrupt-enable bit). It stays high until the flag is cleared or the enable is removed.
- R11: Byte addresses are control 0x00, mode 0x01 (bits 7:4 read 0), IO control 0x02, interrupt enable 0x04, status 0x05 (bit 7 reads 1, bit 6 reads 0), counter 0x06, and compare A, B, C, D at 0x08, 0x0A, 0x0C, 0x0E. Unmapped addresses read 0.
- R12: A counter write takes priority over counting and clearing in the same cycle. Compare writes take effect immediately, whether the channel is running or stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, arms status flag clearing |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for bus_addr |
| run_vec | input | 8 | Shared start vector, one bit per channel |
| sync_clr | input | 1 | Synchronous counter clear request |
| ext_clk | input | 1 | External count clock |
| pin_a_in | input | 1 | Capture input for pin A |
| pin_b_in | input | 1 | Capture input for pin B |
| pin_a_out | output | 1 | Output-compare level for pin A |
| pin_b_out | output | 1 | Output-compare level for pin B |
| irq | output | 1 | Level interrupt request |

## Verification
The bench checks that the match clear lands on the cycle after equality. With compare A at 4 the counter must run with period 5 and read 2 after 12 ticks; an off-by-one clear would give period 4 or 6. It checks that the divider restarts after a stop, so a free-running prescaler would tick too early. It checks that writing 0 to status without a prior read, or writing 1 after a read, leaves the flag set, which catches a clear that ignores the read step. It also checks the exact captured value after the input synchroniser, that a counter write wins over a same-cycle increment, and that sync_clr has no effect when it is not the selected clear source.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
   localparam int unsigned AW    = 5;
   localparam int unsigned NFLAG = 6;

   localparam logic [AW-1:0] OFS_CTRL = 5'h00;
   localparam logic [AW-1:0] OFS_MODE = 5'h01;
   localparam logic [AW-1:0] OFS_IO   = 5'h02;
   localparam logic [AW-1:0] OFS_IE   = 5'h04;
   localparam logic [AW-1:0] OFS_STAT = 5'h05;
   localparam logic [AW-1:0] OFS_CNT  = 5'h06;
   localparam logic [AW-1:0] OFS_CMPA = 5'h08;
   localparam logic [AW-1:0] OFS_CMPB = 5'h0A;
   localparam logic [AW-1:0] OFS_CMPC = 5'h0C;
   localparam logic [AW-1:0] OFS_CMPD = 5'h0E;

   typedef enum logic [1:0] {ACT_KEEP, ACT_LOW, ACT_HIGH, ACT_FLIP} pin_act_e;

   // clear-source code to a one-hot over compare registers A..D
   function automatic logic [3:0] clr_onehot(input logic [2:0] code);
      case (code)
         3'd1:    return 4'b0001;
         3'd2:    return 4'b0010;
         3'd5:    return 4'b0100;
         3'd6:    return 4'b1000;
         default: return 4'b0000;
      endcase
   endfunction

   function automatic pin_act_e match_action(input logic [3:0] code);
      case (code)
         4'd1, 4'd5: return ACT_LOW;
         4'd2, 4'd6: return ACT_HIGH;
         4'd3, 4'd7: return ACT_FLIP;
         default:    return ACT_KEEP;
      endcase
   endfunction

   function automatic logic is_capture(input logic [3:0] code);
      return (code == 4'd8) || (code == 4'd9) || (code == 4'd10);
   endfunction

   // log2 of the internal divide ratio for codes 0..5
   function automatic logic [3:0] div_shift(input logic [2:0] code);
      return {code, 1'b0};
   endfunction
endpackage

// File: rtl/cmt_prescale.sv
module cmt_prescale
   import cmt_pkg::*;
#(
   parameter int unsigned PRE_W       = 10,
   parameter int unsigned SYNC_STAGES = 2
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [2:0] ratio,
   input  logic [1:0] edge_sel,
   input  logic       ext_clk,
   output logic       tick
);
   if (PRE_W < 10) begin : g_bad_pre
      $error("cmt_prescale: PRE_W must cover a divide by 1024");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("cmt_prescale: SYNC_STAGES must be at least 2");
   end

   logic [PRE_W-1:0]       pre_q;
   logic [PRE_W-1:0]       mask;
   logic [SYNC_STAGES-1:0] ext_sy;
   logic                   ext_prev;
   logic                   ext_now;
   logic                   ext_edge;
   logic                   int_tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pre_q <= '0;
      else if (!run) pre_q <= '0;
      else           pre_q <= pre_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_sy   <= '0;
         ext_prev <= 1'b0;
      end else begin
         ext_sy   <= {ext_sy[SYNC_STAGES-2:0], ext_clk};
         ext_prev <= ext_sy[SYNC_STAGES-1];
      end
   end

   assign ext_now = ext_sy[SYNC_STAGES-1];
   assign mask    = ~({PRE_W{1'b1}} << div_shift(ratio));
   assign int_tick = run && ((pre_q & mask) == mask);

   always_comb begin
      case (edge_sel)
         2'd0:    ext_edge = ext_now & ~ext_prev;
         2'd1:    ext_edge = ~ext_now & ext_prev;
         2'd2:    ext_edge = ext_now ^ ext_prev;
         default: ext_edge = 1'b0;
      endcase
   end

   always_comb begin
      if (ratio <= 3'd5)      tick = int_tick;
      else if (ratio == 3'd6) tick = run && ext_edge;
      else                    tick = 1'b0;
   end

   // R3: at divide-by-4 two ticks never fall on adjacent cycles
   a_r3_quarter_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && ratio == 3'd1) |=> (!tick || ratio != 3'd1));
   // R2: a stopped channel produces no tick
   a_r2_no_tick_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && ratio <= 3'd5) |=> ($past(!run) && (pre_q == '0)));
endmodule

// File: rtl/cmt_pin.sv
module cmt_pin
   import cmt_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] cfg,
   input  logic       cfg_wr,
   input  logic [3:0] cfg_new,
   input  logic       match,
   input  logic       pin_in,
   output logic       pin_out,
   output logic       cap_now
);
   logic [SYNC_STAGES-1:0] sy;
   logic                   prev;
   logic                   cur;
   logic                   lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sy   <= '0;
         prev <= 1'b0;
      end else begin
         sy   <= {sy[SYNC_STAGES-2:0], pin_in};
         prev <= sy[SYNC_STAGES-1];
      end
   end

   assign cur = sy[SYNC_STAGES-1];

   always_comb begin
      case (cfg)
         4'd8:    cap_now = cur & ~prev;
         4'd9:    cap_now = ~cur & prev;
         4'd10:   cap_now = cur ^ prev;
         default: cap_now = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= 1'b0;
      end else if (cfg_wr) begin
         if (cfg_new >= 4'd1 && cfg_new <= 4'd3)      lvl_q <= 1'b0;
         else if (cfg_new >= 4'd5 && cfg_new <= 4'd7) lvl_q <= 1'b1;
      end else if (match) begin
         case (match_action(cfg))
            ACT_LOW:  lvl_q <= 1'b0;
            ACT_HIGH: lvl_q <= 1'b1;
            ACT_FLIP: lvl_q <= ~lvl_q;
            default:  lvl_q <= lvl_q;
         endcase
      end
   end

   assign pin_out = lvl_q;

   // R8: a start-low code drives the pin low on the next cycle
   a_r8_start_low: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_new >= 4'd1 && cfg_new <= 4'd3) |=> !pin_out);
   // R8: retain code leaves the pin alone on a match
   a_r8_retain: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_wr && cfg == 4'd0) |=> $stable(pin_out));
endmodule

// File: rtl/cmt_flags.sv
module cmt_flags
   import cmt_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NFLAG-1:0] set,
   input  logic             rd_stat,
   input  logic             wr_stat,
   input  logic [NFLAG-1:0] wdata,
   output logic [NFLAG-1:0] flags
);
   logic [NFLAG-1:0] armed_q;
   logic [NFLAG-1:0] clr;

   assign clr = wr_stat ? (armed_q & ~wdata) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags   <= '0;
         armed_q <= '0;
      end else begin
         flags <= set | (flags & ~clr);
         if (wr_stat)      armed_q <= '0;
         else if (rd_stat) armed_q <= armed_q | flags;
      end
   end

   // R7: writing all ones never clears a flag
   a_r7_ones_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && (&wdata)) |=> (($past(flags) & ~flags) == '0));
   // R7: a new event wins over a same-cycle clear
   a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (|set) |=> ((flags & $past(set)) == $past(set)));
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
   import cmt_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned BUS_W       = 16,
   parameter int unsigned NUM_CMP     = 4,
   parameter int unsigned RUN_W       = 8,
   parameter int unsigned CHAN_IDX    = 0,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned PRE_W       = 10
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    bus_addr,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [BUS_W-1:0] bus_wdata,
   output logic [BUS_W-1:0] bus_rdata,
   input  logic [RUN_W-1:0] run_vec,
   input  logic             sync_clr,
   input  logic             ext_clk,
   input  logic             pin_a_in,
   input  logic             pin_b_in,
   output logic             pin_a_out,
   output logic             pin_b_out,
   output logic             irq
);
   localparam int unsigned MAX_CMP = 4;
   localparam int unsigned NPIN    = 2;

   if (CNT_W < 2 || CNT_W > BUS_W) begin : g_bad_cnt
      $error("cmt_channel: CNT_W must lie in 2..BUS_W");
   end
   if (BUS_W < 8) begin : g_bad_bus
      $error("cmt_channel: BUS_W must be at least 8");
   end
   if (NUM_CMP < NPIN || NUM_CMP > MAX_CMP) begin : g_bad_cmp
      $error("cmt_channel: NUM_CMP must lie in 2..4");
   end
   if (CHAN_IDX >= RUN_W) begin : g_bad_idx
      $error("cmt_channel: CHAN_IDX outside run vector");
   end

   logic [7:0]         ctrl_q, io_q, ie_q;
   logic [3:0]         mode_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [CNT_W-1:0]   cmp_q [MAX_CMP];
   logic [MAX_CMP-1:0] match, cap, cap_mode;
   logic [NPIN-1:0]    pin_cap, pin_lvl, pin_in;
   logic [NFLAG-1:0]   flags, flag_set;
   logic               run, count_en, tick, clr_hit, sync_hit;
   logic               wr_ctrl, wr_mode, wr_io, wr_ie, wr_stat, wr_cnt, rd_stat;
   logic               unused_run;

   assign unused_run = ^run_vec;
   assign run        = run_vec[CHAN_IDX];
   assign count_en   = run && (mode_q == 4'd0);

   assign wr_ctrl = bus_wr && bus_addr == OFS_CTRL;
   assign wr_mode = bus_wr && bus_addr == OFS_MODE;
   assign wr_io   = bus_wr && bus_addr == OFS_IO;
   assign wr_ie   = bus_wr && bus_addr == OFS_IE;
   assign wr_stat = bus_wr && bus_addr == OFS_STAT;
   assign wr_cnt  = bus_wr && bus_addr == OFS_CNT;
   assign rd_stat = bus_rd && bus_addr == OFS_STAT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         mode_q <= '0;
         io_q   <= '0;
         ie_q   <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= bus_wdata[7:0];
         if (wr_mode) mode_q <= bus_wdata[3:0];
         if (wr_io)   io_q   <= bus_wdata[7:0];
         if (wr_ie)   ie_q   <= bus_wdata[7:0];
      end
   end

   cmt_prescale #(.PRE_W(PRE_W), .SYNC_STAGES(SYNC_STAGES)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(count_en), .ratio(ctrl_q[2:0]),
      .edge_sel(ctrl_q[4:3]), .ext_clk(ext_clk), .tick(tick));

   assign pin_in = {pin_b_in, pin_a_in};

   for (genvar p = 0; p < NPIN; p++) begin : g_pin
      cmt_pin #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
         .clk(clk), .rst_n(rst_n), .cfg(io_q[4*p +: 4]), .cfg_wr(wr_io),
         .cfg_new(bus_wdata[4*p +: 4]), .match(match[p]), .pin_in(pin_in[p]),
         .pin_out(pin_lvl[p]), .cap_now(pin_cap[p]));
   end

   assign pin_a_out = pin_lvl[0];
   assign pin_b_out = pin_lvl[1];

   for (genvar i = 0; i < MAX_CMP; i++) begin : g_cmp
      if (i < NUM_CMP) begin : g_on
         logic [CNT_W-1:0] val_q;
         logic             wr_me;
         assign wr_me = bus_wr && bus_addr == (OFS_CMPA + AW'(2 * i));
         if (i < NPIN) begin : g_cap
            assign cap_mode[i] = is_capture(io_q[4*i +: 4]);
            assign cap[i]      = pin_cap[i];
         end else begin : g_nocap
            assign cap_mode[i] = 1'b0;
            assign cap[i]      = 1'b0;
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      val_q <= '1;
            else if (wr_me)  val_q <= bus_wdata[CNT_W-1:0];
            else if (cap[i]) val_q <= cnt_q;
         end
         assign cmp_q[i] = val_q;
         assign match[i] = tick && !cap_mode[i] && (cnt_q == val_q);
      end else begin : g_off
         assign cmp_q[i]    = '1;
         assign cap_mode[i] = 1'b0;
         assign cap[i]      = 1'b0;
         assign match[i]    = 1'b0;
      end
   end

   assign clr_hit  = |(match & clr_onehot(ctrl_q[7:5]));
   assign sync_hit = count_en && (ctrl_q[7:5] == 3'd3) && sync_clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (wr_cnt)   cnt_q <= bus_wdata[CNT_W-1:0];
      else if (sync_hit) cnt_q <= '0;
      else if (tick)     cnt_q <= clr_hit ? '0 : cnt_q + 1'b1;
   end

   assign flag_set = {1'b0,
                      tick && !wr_cnt && !sync_hit && !clr_hit && (&cnt_q),
                      match | cap};

   cmt_flags u_flags (
      .clk(clk), .rst_n(rst_n), .set(flag_set), .rd_stat(rd_stat),
      .wr_stat(wr_stat), .wdata(bus_wdata[NFLAG-1:0]), .flags(flags));

   assign irq = |(flags & ie_q[NFLAG-1:0]);

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         OFS_CTRL: bus_rdata[7:0] = ctrl_q;
         OFS_MODE: bus_rdata[3:0] = mode_q;
         OFS_IO:   bus_rdata[7:0] = io_q;
         OFS_IE:   bus_rdata[7:0] = ie_q;
         OFS_STAT: bus_rdata[7:0] = {2'b10, flags};
         OFS_CNT:  bus_rdata = BUS_W'(cnt_q);
         OFS_CMPA: bus_rdata = BUS_W'(cmp_q[0]);
         OFS_CMPB: bus_rdata = BUS_W'(cmp_q[1]);
         OFS_CMPC: bus_rdata = BUS_W'(cmp_q[2]);
         OFS_CMPD: bus_rdata = BUS_W'(cmp_q[3]);
         default:  bus_rdata = '0;
      endcase
   end

   // R2: with no run and no write the counter holds
   a_r2_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !wr_cnt) |=> (cnt_q == $past(cnt_q)));
   // R4: a compare A match with A selected as clear source returns to zero
   a_r4_clear_on_a: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && ctrl_q[7:5] == 3'd1 && !cap_mode[0] && cnt_q == cmp_q[0] && !wr_cnt)
      |=> (cnt_q == '0));
   // R5: wrapping past all ones raises the overflow flag
   a_r5_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && (&cnt_q) && !wr_cnt && !sync_hit && !clr_hit) |=> (cnt_q == '0 && flags[4]));
   // R10: the interrupt holds until status or enable is written
   a_r10_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !wr_stat && !wr_ie) |=> irq);
   // R12: a counter write wins over counting
   a_r12_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cnt |=> (cnt_q == $past(bus_wdata[CNT_W-1:0])));
endmodule

// File: tb/sim_cmt_channel.sv
module sim_cmt_channel;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  addr = '0;
   logic        wr = 1'b0, rd = 1'b0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic [7:0]  run_vec = '0;
   logic        sync_clr = 1'b0, ext_clk = 1'b0, pa_in = 1'b0, pb_in = 1'b0;
   logic        pa_out, pb_out, irq;
   int          n_chk = 0, n_bad = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   cmt_channel u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
      .bus_wdata(wdata), .bus_rdata(rdata), .run_vec(run_vec), .sync_clr(sync_clr),
      .ext_clk(ext_clk), .pin_a_in(pa_in), .pin_b_in(pb_in),
      .pin_a_out(pa_out), .pin_b_out(pb_out), .irq(irq));

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [4:0] a, input logic [15:0] d);
      @(negedge clk); addr = a; wdata = d; wr = 1'b1;
      @(posedge clk);
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic bus_read(input logic [4:0] a, output logic [15:0] d);
      @(negedge clk); addr = a; rd = 1'b1;
      #1 d = rdata;
      @(posedge clk);
      @(negedge clk); rd = 1'b0;
   endtask

   task automatic peek(input logic [4:0] a, output logic [15:0] d);
      @(negedge clk); addr = a;
      #1 d = rdata;
   endtask

   task automatic run_for(input int k);
      @(negedge clk); run_vec[0] = 1'b1;
      repeat (k) @(posedge clk);
      @(negedge clk); run_vec[0] = 1'b0;
   endtask

   task automatic clear_flags();
      logic [15:0] d;
      bus_read(5'h05, d);
      bus_write(5'h05, 16'h0000);
   endtask

   task automatic t_reset();
      logic [15:0] d;
      peek(5'h00, d); check("R1 ctrl", d, 16'h0000);
      peek(5'h05, d); check("R1 R11 status", d, 16'h0080);
      peek(5'h06, d); check("R1 counter", d, 16'h0000);
      peek(5'h08, d); check("R1 cmpA", d, 16'hFFFF);
      peek(5'h0E, d); check("R1 cmpD", d, 16'hFFFF);
      peek(5'h03, d); check("R11 unmapped", d, 16'h0000);
      check("R1 pins", {14'd0, pb_out, pa_out}, 16'h0000);
      check("R1 irq", {15'd0, irq}, 16'h0000);
   endtask

   task automatic t_run_gate();
      logic [15:0] d;
      @(negedge clk); run_vec = 8'hFE;
      repeat (5) @(posedge clk);
      @(negedge clk); run_vec = 8'h00;
      peek(5'h06, d); check("R2 foreign run bits", d, 16'd0);
      run_for(10);
      peek(5'h06, d); check("R2 counts while run", d, 16'd10);
      bus_write(5'h01, 16'h00F2);
      peek(5'h01, d); check("R11 mode high bits", d, 16'h0002);
      run_for(5);
      peek(5'h06, d); check("R2 mode hold", d, 16'd10);
      bus_write(5'h01, 16'h0000);
   endtask

   task automatic t_prescale();
      logic [15:0] d;
      bus_write(5'h00, 16'h0002);
      bus_write(5'h06, 16'h0000);
      run_for(40);
      peek(5'h06, d); check("R3 div16", d, 16'd2);
      run_for(15);
      peek(5'h06, d); check("R3 divider restart", d, 16'd2);
      run_for(16);
      peek(5'h06, d); check("R3 div16 again", d, 16'd3);
      bus_write(5'h00, 16'h0001);
      bus_write(5'h06, 16'h0000);
      run_for(9);
      peek(5'h06, d); check("R3 div4", d, 16'd2);
      bus_write(5'h00, 16'h0007);
      run_for(20);
      peek(5'h06, d); check("R3 code7 idle", d, 16'd2);
   endtask

   task automatic t_ext();
      logic [15:0] d;
      bus_write(5'h00, 16'h0016);
      bus_write(5'h06, 16'h0000);
      @(negedge clk); run_vec[0] = 1'b1;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk); ext_clk = ~ext_clk;
         repeat (6) @(posedge clk);
      end
      @(negedge clk); run_vec[0] = 1'b0;
      peek(5'h06, d); check("R3 ext both edges", d, 16'd4);
      bus_write(5'h00, 16'h0006);
      @(negedge clk); run_vec[0] = 1'b1;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk); ext_clk = ~ext_clk;
         repeat (6) @(posedge clk);
      end
      @(negedge clk); run_vec[0] = 1'b0;
      peek(5'h06, d); check("R3 ext rising", d, 16'd6);
   endtask

   task automatic t_clear();
      logic [15:0] d;
      clear_flags();
      bus_write(5'h00, 16'h0020);
      bus_write(5'h08, 16'd4);
      bus_write(5'h06, 16'h0000);
      run_for(12);
      peek(5'h06, d); check("R4 clear on A", d, 16'd2);
      peek(5'h05, d); check("R6 flag A", d & 16'h0001, 16'h0001);
      bus_write(5'h00, 16'h00C0);
      bus_write(5'h0E, 16'd2);
      bus_write(5'h06, 16'h0000);
      run_for(7);
      peek(5'h06, d); check("R4 clear on D", d, 16'd1);
      peek(5'h05, d); check("R6 flag D", d & 16'h0008, 16'h0008);
      bus_write(5'h00, 16'h0060);
      bus_write(5'h06, 16'd100);
      @(negedge clk); sync_clr = 1'b1; run_vec[0] = 1'b1;
      @(posedge clk);
      @(negedge clk); sync_clr = 1'b0; run_vec[0] = 1'b0;
      peek(5'h06, d); check("R4 sync clear", d, 16'd0);
      run_for(3);
      peek(5'h06, d); check("R4 count after sync", d, 16'd3);
      bus_write(5'h00, 16'h0000);
      bus_write(5'h06, 16'd100);
      @(negedge clk); sync_clr = 1'b1; run_vec[0] = 1'b1;
      @(posedge clk);
      @(negedge clk); sync_clr = 1'b0; run_vec[0] = 1'b0;
      peek(5'h06, d); check("R4 sync not selected", d, 16'd101);
   endtask

   task automatic t_ovf_flags();
      logic [15:0] d;
      clear_flags();
      peek(5'h05, d); check("R7 all cleared", d, 16'h0080);
      bus_write(5'h06, 16'hFFFE);
      run_for(2);
      peek(5'h06, d); check("R5 wrap", d, 16'h0000);
      peek(5'h05, d); check("R5 overflow flag", d & 16'h0010, 16'h0010);
      bus_write(5'h04, 16'h0010);
      check("R10 irq on", {15'd0, irq}, 16'h0001);
      bus_write(5'h05, 16'h0000);
      peek(5'h05, d); check("R7 no read no clear", d & 16'h0010, 16'h0010);
      bus_read(5'h05, d);
      bus_write(5'h05, 16'h00FF);
      peek(5'h05, d); check("R7 write one keeps", d & 16'h0010, 16'h0010);
      bus_write(5'h04, 16'h0000);
      check("R10 irq masked", {15'd0, irq}, 16'h0000);
      bus_write(5'h04, 16'h0010);
      bus_read(5'h05, d);
      bus_write(5'h05, 16'h00EF);
      peek(5'h05, d); check("R7 read then zero", d & 16'h0010, 16'h0000);
      check("R10 irq drops", {15'd0, irq}, 16'h0000);
      bus_write(5'h04, 16'h0000);
   endtask

   task automatic t_outcmp();
      logic [15:0] d;
      bus_write(5'h00, 16'h0020);
      bus_write(5'h08, 16'd3);
      bus_write(5'h0A, 16'd1);
      bus_write(5'h06, 16'h0000);
      bus_write(5'h02, 16'h0063);
      check("R8 initial levels", {14'd0, pb_out, pa_out}, 16'h0002);
      run_for(4);
      check("R8 toggle A high", {15'd0, pa_out}, 16'h0001);
      check("R8 set B", {15'd0, pb_out}, 16'h0001);
      run_for(4);
      check("R8 toggle A low", {15'd0, pa_out}, 16'h0000);
      bus_write(5'h02, 16'h0057);
      check("R8 start high", {14'd0, pb_out, pa_out}, 16'h0003);
      run_for(2);
      check("R8 clear B", {15'd0, pb_out}, 16'h0000);
      bus_write(5'h02, 16'h0000);
      run_for(6);
      check("R8 retain", {14'd0, pb_out, pa_out}, 16'h0001);
      peek(5'h06, d);
   endtask

   task automatic t_capture();
      logic [15:0] d;
      bus_write(5'h00, 16'h0000);
      bus_write(5'h02, 16'h0008);
      bus_write(5'h08, 16'd3);
      bus_write(5'h06, 16'h0000);
      clear_flags();
      @(negedge clk); run_vec[0] = 1'b1;
      repeat (5) @(posedge clk);
      @(negedge clk);
      #1 addr = 5'h05;
      #1 check("R9 no match in capture", rdata & 16'h0001, 16'h0000);
      pa_in = 1'b1;
      repeat (5) @(posedge clk);
      @(negedge clk); run_vec[0] = 1'b0;
      peek(5'h08, d); check("R9 captured value", d, 16'd7);
      peek(5'h05, d); check("R9 capture flag", d & 16'h0001, 16'h0001);
      peek(5'h06, d); check("R9 counter ran on", d, 16'd10);
      pa_in = 1'b0;
      bus_write(5'h02, 16'h0000);
   endtask

   task automatic t_priority();
      logic [15:0] d;
      bus_write(5'h00, 16'h0000);
      @(negedge clk); run_vec[0] = 1'b1; addr = 5'h06; wdata = 16'h1234; wr = 1'b1;
      @(posedge clk);
      @(negedge clk); wr = 1'b0; run_vec[0] = 1'b0;
      peek(5'h06, d); check("R12 write beats count", d, 16'h1234);
      run_for(3);
      peek(5'h06, d); check("R12 counts from written", d, 16'h1237);
      bus_write(5'h0C, 16'hABCD);
      peek(5'h0C, d); check("R12 R11 cmpC write", d, 16'hABCD);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      t_reset();
      t_run_gate();
      t_prescale();
      t_ext();
      t_clear();
      t_ovf_flags();
      t_outcmp();
      t_capture();
      t_priority();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule